// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital wrapper around an external analog comparator. It passes the comparator's binary output through a two-flop synchronizer and presents the result as a read-only status bit. It watches that synchronized value for a selectable kind of edge and sets a sticky interrupt flag when that edge occurs. It also forms an interrupt request and can forward the comparator level to a timer's input-capture trigger.

Software sees one 8-bit control/status register. Writing the register updates the power-down bit, the interrupt enable, the capture-route bit and the 2-bit edge mode. Writing a 1 into the flag position clears the flag. The flag also clears when the interrupt controller acknowledges the request.

Setting the power-down bit switches the comparator off. The synchronizer then freezes, so no edge can be seen while the comparator is off.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset, every writable field is 0 and, with the comparator input held low, `reg_rdata` reads 0x00.
- R2: Bit 5 of `reg_rdata` shows the comparator input after two synchronizer flops. Writes to bit 5 have no effect.
- R3: Bit 6 of `reg_rdata` always reads 0, whatever is written to it.
- R4: With mode field bits [1:0] = 00, any change of the synchronized comparator value sets the flag (bit 4).
- R5: Mode 10 sets the flag only on a 1-to-0 change of the synchronized value. Mode 11 sets it only on a 0-to-1 change.
- R6: Mode 01 is reserved and never sets the flag.
- R7: A write with bit 4 = 1 clears the flag. A write with bit 4 = 0 leaves the flag unchanged.
- R8: A one-cycle pulse on `irq_ack` clears the flag.
- R9: If an edge event arrives in the same cycle as a flag clear (by write or by acknowledge), the flag ends up set.
- R10: `irq_req` equals flag AND interrupt enable (bit 3) AND `gie`.
- R11: When capture route (bit 2) is 1, `cap_trig` follows the synchronized comparator value. When bit 2 is 0, `cap_trig` is 0.
- R12: Power-down (bit 7) drives `cmp_pwr_off`. While it is 1, the synchronized value and bit 5 hold their last value and no event sets the flag. After power-down is cleared, a difference between the held value and the input counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request |
| cap_trig | output | 1 | Input-capture trigger to timer |
| cmp_pwr_off | output | 1 | Comparator power-down control |

## Verification
The hardest case to reach is a flag clear that lands in the single cycle in which the edge detector fires. That cycle comes two clock edges after the input changes. The directed stimulus changes `cmp_raw`, counts two rising edges, and only then asserts the clearing write or the acknowledge, once for each clear path.

Random stimulus interleaves:
- input toggles,
- mode and enable writes,
- power-down on/off sequences with the input moving while the comparator is off.

This exercises the re-enable edge of R12 against a bench model of the held value.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

   // register field positions (bit 6 is a constant zero)
   localparam int unsigned BIT_PWR_OFF = 7;
   localparam int unsigned BIT_ZERO    = 6;
   localparam int unsigned BIT_STATUS  = 5;
   localparam int unsigned BIT_FLAG    = 4;
   localparam int unsigned BIT_IE      = 3;
   localparam int unsigned BIT_CAP     = 2;
   localparam int unsigned BIT_MODE_HI = 1;
   localparam int unsigned BIT_MODE_LO = 0;
   localparam int unsigned FIELD_BITS  = 8;

   typedef enum logic [1:0] {
      MODE_TOGGLE = 2'b00,
      MODE_RSVD   = 2'b01,
      MODE_FALL   = 2'b10,
      MODE_RISE   = 2'b11
   } edge_mode_e;

   typedef struct packed {
      logic       pwr_off;
      logic       ie;
      logic       cap_en;
      edge_mode_e mode;
   } ctrl_fields_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic d,
   output logic q
);
   localparam int unsigned LAST = STAGES - 1;

   logic [LAST:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cmp_sync: STAGES must be at least 2");
      end
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    chain[0] <= RST_VAL;
               else if (!hold) chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)    chain[gi] <= RST_VAL;
               else if (!hold) chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[LAST];
endmodule

// File: rtl/cmp_edge_sel.sv
module cmp_edge_sel
   import cmp_irq_pkg::*;
#(
   parameter bit RST_VAL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp,
   input  edge_mode_e mode,
   output logic       evt
);
   logic prev;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= smp;
   end

   assign rise = smp & ~prev;
   assign fall = ~smp & prev;

   always_comb begin
      unique case (mode)
         MODE_TOGGLE: evt = rise | fall;
         MODE_FALL:   evt = fall;
         MODE_RISE:   evt = rise;
         default:     evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
   import cmp_irq_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wen,
   input  logic             wr_pwr_off,
   input  logic             wr_flag,
   input  logic             wr_ie,
   input  logic             wr_cap,
   input  logic [1:0]       wr_mode,
   input  logic             ack,
   input  logic             evt,
   input  logic             status,
   output ctrl_fields_t     ctrl,
   output logic             flag,
   output logic [REG_W-1:0] rdata
);
   localparam int unsigned PAD_W = REG_W - FIELD_BITS;

   generate
      if (REG_W < FIELD_BITS) begin : g_bad_width
         $error("cmp_ctrl_regs: REG_W too small for the field layout");
      end
   endgenerate

   logic flag_clr;

   assign flag_clr = (wen & wr_flag) | ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '{pwr_off: 1'b0, ie: 1'b0, cap_en: 1'b0, mode: MODE_TOGGLE};
      end else if (wen) begin
         ctrl.pwr_off <= wr_pwr_off;
         ctrl.ie      <= wr_ie;
         ctrl.cap_en  <= wr_cap;
         ctrl.mode    <= edge_mode_e'(wr_mode);
      end
   end

   // a new event takes priority over any clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (evt)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   logic [FIELD_BITS-1:0] fields;

   always_comb begin
      fields                           = '0;
      fields[BIT_PWR_OFF]              = ctrl.pwr_off;
      fields[BIT_ZERO]                 = 1'b0;
      fields[BIT_STATUS]               = status;
      fields[BIT_FLAG]                 = flag;
      fields[BIT_IE]                   = ctrl.ie;
      fields[BIT_CAP]                  = ctrl.cap_en;
      fields[BIT_MODE_HI:BIT_MODE_LO]  = ctrl.mode;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = {{PAD_W{1'b0}}, fields};
      end else begin : g_nopad
         assign rdata = fields;
      end
   endgenerate
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
   import cmp_irq_pkg::*;
#(
   parameter int unsigned REG_W          = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          CAP_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_raw,
   input  logic             reg_wen,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             irq_ack,
   input  logic             gie,
   output logic             irq_req,
   output logic             cap_trig,
   output logic             cmp_pwr_off
);
   ctrl_fields_t ctrl;
   logic         cmp_s;
   logic         evt_hit;
   logic         flag;

   cmp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (ctrl.pwr_off),
      .d     (cmp_raw),
      .q     (cmp_s)
   );

   cmp_edge_sel #(.RST_VAL(1'b0)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .smp   (cmp_s),
      .mode  (ctrl.mode),
      .evt   (evt_hit)
   );

   cmp_ctrl_regs #(.REG_W(REG_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wen        (reg_wen),
      .wr_pwr_off (reg_wdata[BIT_PWR_OFF]),
      .wr_flag    (reg_wdata[BIT_FLAG]),
      .wr_ie      (reg_wdata[BIT_IE]),
      .wr_cap     (reg_wdata[BIT_CAP]),
      .wr_mode    (reg_wdata[BIT_MODE_HI:BIT_MODE_LO]),
      .ack        (irq_ack),
      .evt        (evt_hit),
      .status     (cmp_s),
      .ctrl       (ctrl),
      .flag       (flag),
      .rdata      (reg_rdata)
   );

   assign irq_req     = flag & ctrl.ie & gie;
   assign cmp_pwr_off = ctrl.pwr_off;

   generate
      if (CAP_REGISTERED) begin : g_cap_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cap_trig <= 1'b0;
            else        cap_trig <= ctrl.cap_en & cmp_s;
         end
      end else begin : g_cap_comb
         assign cap_trig = ctrl.cap_en & cmp_s;
      end
   endgenerate
endmodule

// File: rtl/cmp_irq_chk.sv
module cmp_irq_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wen,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             irq_ack,
   input logic             gie,
   input logic             irq_req,
   input logic             cap_trig,
   input logic             cmp_pwr_off,
   input logic             evt
);
   assert_zero_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[6] == 1'b0);

   assert_irq_and_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (reg_rdata[4] & reg_rdata[3] & gie));

   assert_no_rsvd_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[4]) |-> $past(reg_rdata[1:0]) != 2'b01);

   assert_cap_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[2] |-> !cap_trig);

   assert_write_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wen && reg_wdata[4] && !evt) |=> !reg_rdata[4]);

   assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !evt) |=> !reg_rdata[4]);

   assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> reg_rdata[4]);

   assert_hold_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_pwr_off && $past(cmp_pwr_off)) |-> $stable(reg_rdata[5]));
endmodule

bind cmp_irq_ctrl cmp_irq_chk #(.REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wen     (reg_wen),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .irq_ack     (irq_ack),
   .gie         (gie),
   .irq_req     (irq_req),
   .cap_trig    (cap_trig),
   .cmp_pwr_off (cmp_pwr_off),
   .evt         (evt_hit)
);

// File: tb/sim_cmp_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cmp_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw = 1'b0;
   logic       reg_wen = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_ack = 1'b0;
   logic       gie = 1'b0;
   logic       irq_req;
   logic       cap_trig;
   logic       cmp_pwr_off;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // bench model
   bit m_off, m_ie, m_cap, m_flag, m_s;
   bit [1:0] m_mode;

   always #5 clk = ~clk;

   cmp_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
      .gie(gie), .irq_req(irq_req), .cap_trig(cap_trig), .cmp_pwr_off(cmp_pwr_off)
   );

   function automatic bit hit(input bit [1:0] md, input bit old_v, input bit new_v);
      case (md)
         2'b00:   return old_v != new_v;
         2'b10:   return old_v & ~new_v;
         2'b11:   return ~old_v & new_v;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit [7:0] exp_reg();
      return {m_off, 1'b0, m_s, m_flag, m_ie, m_cap, m_mode};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
      if (!m_off && (cmp_raw != m_s)) begin
         if (hit(m_mode, m_s, cmp_raw)) m_flag = 1'b1;
         m_s = cmp_raw;
      end
   endtask

   task automatic wr(input bit [7:0] d);
      @(negedge clk);
      reg_wen = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
      m_off = d[7]; m_ie = d[3]; m_cap = d[2]; m_mode = d[1:0];
      if (d[4]) m_flag = 1'b0;
      settle();
   endtask

   task automatic ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      m_flag = 1'b0;
      settle();
   endtask

   task automatic check_all(input string tag);
      check(tag, reg_rdata, exp_reg());
      check("R10 irq", {7'd0, irq_req}, {7'd0, m_flag & m_ie & gie});
      check("R11 cap", {7'd0, cap_trig}, {7'd0, m_cap & m_s});
      check("R12 pwr", {7'd0, cmp_pwr_off}, {7'd0, m_off});
   endtask

   // coincident clear: c_kind 0 = write clear, 1 = acknowledge
   task automatic coincide(input bit c_kind);
      @(negedge clk);
      cmp_raw = ~cmp_raw;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      if (c_kind) irq_ack = 1'b1;
      else begin
         reg_wen = 1'b1;
         reg_wdata = {m_off, 1'b0, 1'b0, 1'b1, m_ie, m_cap, m_mode};
      end
      @(negedge clk);
      irq_ack = 1'b0; reg_wen = 1'b0;
      m_flag = 1'b0;
      settle();
      check(c_kind ? "R9 ack-vs-event" : "R9 write-vs-event", reg_rdata, exp_reg());
   endtask

   initial begin
      bit [31:0] r;
      r = $urandom(32'h1234_abcd);
      m_off = 0; m_ie = 0; m_cap = 0; m_flag = 0; m_s = 0; m_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", reg_rdata, 8'h00);
      check("R1 irq", {7'd0, irq_req}, 8'h00);

      // R2 status follows input, write to bit 5 ignored
      cmp_raw = 1'b1; settle();
      check("R2 status high / R4 toggle", reg_rdata, exp_reg());
      wr(8'h10);
      check("R7 write-1 clears", reg_rdata, exp_reg());
      cmp_raw = 1'b0; settle();
      wr(8'h20);
      check("R2 status write ignored", reg_rdata, exp_reg());
      // R3
      wr(8'h40);
      check("R3 bit6 zero", reg_rdata, exp_reg());
      // R5 rise/fall
      wr(8'h13); cmp_raw = 1'b1; settle();
      check("R5 rise sets", reg_rdata, exp_reg());
      wr(8'h03); cmp_raw = 1'b0; settle();
      check("R7 write-0 keeps", reg_rdata, exp_reg());
      wr(8'h12); cmp_raw = 1'b1; settle();
      check("R5 fall ignores rise", reg_rdata, exp_reg());
      cmp_raw = 1'b0; settle();
      check("R5 fall sets", reg_rdata, exp_reg());
      // R6
      wr(8'h11); cmp_raw = 1'b1; settle(); cmp_raw = 1'b0; settle();
      check("R6 reserved", reg_rdata, exp_reg());
      // R8, R10
      gie = 1'b1; wr(8'h08); cmp_raw = 1'b1; settle();
      check_all("R10 request");
      ack();
      check("R8 ack clears", reg_rdata, exp_reg());
      // R9 coincidences
      coincide(1'b0);
      coincide(1'b1);
      // R11
      wr(8'h04); check_all("R11 route on");
      // R12 off, input moves, back on
      wr(8'h80); cmp_raw = ~cmp_raw; settle();
      check_all("R12 held while off");
      wr(8'h00);
      check_all("R12 re-enable edge");

      // random phase
      for (int i = 0; i < 400; i++) begin
         r = $urandom % 8;
         gie = $urandom % 2;
         if (r < 4) begin
            cmp_raw = $urandom % 2; settle();
         end else if (r < 6) begin
            wr({(($urandom % 4) == 0) ? 1'b1 : 1'b0, 1'($urandom % 2),
                1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                1'($urandom % 2), 2'($urandom % 4)});
         end else if (r == 6) begin
            ack();
         end else begin
            settle();
         end
         if (m_off)               check_all("R12 rand");
         else if (m_mode == 2'b01) check_all("R6 rand");
         else if (m_mode == 2'b00) check_all("R4 rand");
         else                      check_all("R5 rand");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule